// File: doc/BRIEF.md
# Peripheral Register Page Selector

This block holds the page number that steers a narrow register window onto one of several banks of peripheral registers. Software writes one control byte, and the block turns it into the page number that feeds the bank address decode. Its output is the current page, and a readback path lets software see the page it has set.

Each write also carries an operation code. One code copies the current page into one of four hidden storage slots and loads a new page in the same cycle. Another code discards the written page bits and loads the page from a chosen slot. An interrupt handler can therefore switch pages on entry and return to the interrupted page on exit with one write each, without reading the page first. The other two codes load the written page directly and leave all slots alone.

Control byte layout: bits [7:6] operation, bits [5:4] slot number, bit [3] reserved, bits [2:0] page number.

Top module: `pgsel_top`

## Requirements
- R1: After synchronous reset the page output is 0, the readback is 8'h00, and all four storage slots hold 0, so a restore from any slot right after reset gives page 0.
- R2: A write with operation 2'b00 or 2'b01 loads bits [2:0] of the byte into the page and changes no storage slot.
- R3: A write with operation 2'b10 stores the page held before the write into the slot chosen by bits [5:4], and in the same cycle loads bits [2:0] of the byte into the page.
- R4: A write with operation 2'b11 loads the page from the slot chosen by bits [5:4] and ignores bits [2:0] of the byte.
- R5: Slot numbers 2'b00, 2'b01, 2'b10 and 2'b11 select four separate slots; a save to one slot leaves the other three unchanged.
- R6: The readback has the page in bits [2:0] and 0 in bits [7:3]; operation, slot and reserved bits are never read back.
- R7: The page output changes on the clock edge that samples the write strobe and is visible in the following cycle; without a write strobe the page holds its value.
- R8: Two nested save/restore pairs that use different slots return the page to the value it had before the outer save.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte: operation, slot number, reserved bit, page |
| rd_data | output | 8 | Readback: page in the low bits, zeros above |
| page_o | output | 3 | Current page number to the bank address decode |

## Verification
On every cycle the assertions check that the page holds while no write strobe is present, that direct and save writes put the written page on the output one cycle later, that the upper readback bits stay zero and that reset leaves the page at 0. Whether a restore returns the right slot's value, whether one save disturbs another slot, and whether nested save/restore pairs bring back the original page depend on history held across many writes, so only the bench scenarios show them: a sweep of all 256 control bytes against an arithmetic model, per-slot restores after reset and a nested two-slot sequence.

// File: rtl/pgsel_pkg.sv
package pgsel_pkg;

    // Geometry of the control byte and the save area
    localparam int DATA_W   = 8;
    localparam int PAGE_W   = 3;
    localparam int SLOT_CNT = 4;
    localparam int SLOT_W   = $clog2(SLOT_CNT);
    localparam int OP_W     = 2;

    // Field positions inside the control byte
    localparam int PAGE_LSB = 0;
    localparam int SEL_LSB  = 4;
    localparam int OP_LSB   = 6;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD_A  = 2'b00,
        OP_LOAD_B  = 2'b01,
        OP_SAVE    = 2'b10,
        OP_RESTORE = 2'b11
    } pg_op_e;

    typedef struct packed {
        pg_op_e              op;
        logic [SLOT_W-1:0]   sel;
        logic [PAGE_W-1:0]   page;
    } pg_cmd_t;

    // Split a control byte into its fields
    function automatic pg_cmd_t unpack_cmd(input logic [DATA_W-1:0] b);
        pg_cmd_t c;
        c.op   = pg_op_e'(b[OP_LSB +: OP_W]);
        c.sel  = b[SEL_LSB +: SLOT_W];
        c.page = b[PAGE_LSB +: PAGE_W];
        return c;
    endfunction

    // Place a page value into a readback byte, zeros elsewhere
    function automatic logic [DATA_W-1:0] pack_readback(input logic [PAGE_W-1:0] p);
        logic [DATA_W-1:0] r;
        r = '0;
        r[PAGE_LSB +: PAGE_W] = p;
        return r;
    endfunction

endpackage

// File: rtl/pgsel_decode.sv
module pgsel_decode
    import pgsel_pkg::*;
(
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [SLOT_CNT-1:0] save_vec,
    output logic                restore_en,
    output logic                load_en,
    output logic [SLOT_W-1:0]   sel,
    output logic [PAGE_W-1:0]   new_page
);

    pg_cmd_t cmd;

    always_comb begin
        cmd        = unpack_cmd(wr_data);
        sel        = cmd.sel;
        new_page   = cmd.page;
        restore_en = 1'b0;
        load_en    = 1'b0;
        save_vec   = '0;
        if (wr_en) begin
            unique case (cmd.op)
                OP_LOAD_A, OP_LOAD_B: load_en = 1'b1;
                OP_SAVE: begin
                    load_en            = 1'b1;
                    save_vec[cmd.sel]  = 1'b1;
                end
                OP_RESTORE: restore_en = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pgsel_slots.sv
module pgsel_slots
    import pgsel_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SLOT_CNT-1:0] save_vec,
    input  logic [PAGE_W-1:0]   save_val,
    input  logic [SLOT_W-1:0]   rd_sel,
    output logic [PAGE_W-1:0]   rd_val
);

    logic [PAGE_W-1:0] slot_q [SLOT_CNT];

    for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (save_vec[g])
                slot_q[g] <= save_val;
        end
    end

    assign rd_val = slot_q[rd_sel];

endmodule

// File: rtl/pgsel_top.sv
module pgsel_top
    import pgsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic [2:0]        page_o
);

    logic [SLOT_CNT-1:0] save_vec;
    logic                restore_en;
    logic                load_en;
    logic [SLOT_W-1:0]   sel;
    logic [PAGE_W-1:0]   new_page;
    logic [PAGE_W-1:0]   slot_val;
    logic [PAGE_W-1:0]   page_q;

    pgsel_decode u_decode (
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .save_vec   (save_vec),
        .restore_en (restore_en),
        .load_en    (load_en),
        .sel        (sel),
        .new_page   (new_page)
    );

    // Save captures the page held before this write
    pgsel_slots u_slots (
        .clk      (clk),
        .rst      (rst),
        .save_vec (save_vec),
        .save_val (page_q),
        .rd_sel   (sel),
        .rd_val   (slot_val)
    );

    always_ff @(posedge clk) begin
        if (rst)
            page_q <= '0;
        else if (restore_en)
            page_q <= slot_val;
        else if (load_en)
            page_q <= new_page;
    end

    assign page_o  = page_q;
    assign rd_data = pack_readback(page_q);

endmodule

// File: rtl/pgsel_chk.sv
module pgsel_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [2:0] page_o
);

    // R1
    reset_page_zero_chk: assert property (@(posedge clk)
        rst |=> (page_o == 3'd0));

    // R7
    page_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(page_o));

    // R2
    direct_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[7]) |=> (page_o == $past(wr_data[2:0])));

    // R3
    save_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[7:6] == 2'b10) |=> (page_o == $past(wr_data[2:0])));

    // R6
    readback_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:3] == 5'd0);

endmodule

bind pgsel_top pgsel_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .page_o  (page_o)
);

// File: tb/pgsel_top_tb_top.sv
module pgsel_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [2:0] page_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [2:0] mdl_page;
    logic [2:0] mdl_slot [4];

    always #5 clk = ~clk;

    pgsel_top dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .page_o  (page_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one write; returns at the falling edge after the sampling edge
    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    // Model update from the requirements
    task automatic model(input logic [7:0] b);
        logic [1:0] op;
        logic [1:0] s;
        op = b[7:6];
        s  = b[5:4];
        if (op == 2'b11) mdl_page = mdl_slot[s];
        else begin
            if (op == 2'b10) mdl_slot[s] = mdl_page;
            mdl_page = b[2:0];
        end
    endtask

    task automatic wr_chk(input string req, input logic [7:0] b);
        wr(b);
        model(b);
        check(req, {5'd0, page_o}, {5'd0, mdl_page});
        check("R6", rd_data, {5'd0, mdl_page});
    endtask

    initial begin
        for (int i = 0; i < 4; i++) mdl_slot[i] = 3'd0;
        mdl_page = 3'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", {5'd0, page_o}, 8'h00);
        check("R1", rd_data, 8'h00);
        // R1 slots zero after reset: set page then restore each slot
        for (int s = 0; s < 4; s++) begin
            wr_chk("R2", 8'h05);
            wr_chk("R1", {2'b11, s[1:0], 4'b0111});
        end
        // R7 change visible the cycle after the strobe
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h06;
        check("R7", {5'd0, page_o}, 8'h00);
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
        model(8'h06);
        check("R7", {5'd0, page_o}, 8'h06);
        // R7 hold with no strobe, even with data toggling
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            wr_data = 8'h41 + 8'(k);
            @(negedge clk);
            check("R7", {5'd0, page_o}, 8'h06);
        end
        wr_data = 8'h00;
        // Sweep of every control byte: R2, R3, R4, R5, R6
        for (int b = 0; b < 256; b++) begin
            case (b[7:6])
                2'b00, 2'b01: wr_chk("R2", 8'(b));
                2'b10:        wr_chk("R3", 8'(b));
                default:      wr_chk("R4", 8'(b));
            endcase
        end
        // R5 slots distinct: fill each with its own value, read back all
        for (int s = 0; s < 4; s++) begin
            wr_chk("R2", {5'd0, 3'(s + 1)});
            wr_chk("R5", {2'b10, s[1:0], 4'b0000});
        end
        for (int s = 3; s >= 0; s--) begin
            wr_chk("R5", {2'b11, s[1:0], 4'b0000});
            check("R5", {5'd0, page_o}, 8'(s + 1));
        end
        // R8 nested save/restore with slots 1 and 3
        wr_chk("R2", 8'h05);
        wr_chk("R8", 8'h92);   // save to slot 1, load 2
        wr_chk("R8", 8'hB6);   // save to slot 3, load 6
        wr_chk("R8", 8'hF1);   // restore slot 3 -> 2
        check("R8", {5'd0, page_o}, 8'h02);
        wr_chk("R8", 8'hD7);   // restore slot 1 -> 5
        check("R8", {5'd0, page_o}, 8'h05);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule